// File: doc/BRIEF.md
# Indexed-Write Command Packer

This block builds, in hardware, the command buffer that a register-programming engine later fetches and executes. Each incoming request carries a 20-bit register offset, a 32-bit value and a flag that marks it as a direct write or an indexed (auto-increment) write. The packer turns each request into 32-bit command words and stores them in a local buffer memory. It keeps a free-position pointer and the position where the most recent instruction begins.

Back-to-back indexed writes to the same register are folded into one instruction. The new value is appended, and the count word at the start of that instruction is rewritten. Each indexed instruction starts on an even word. A word left half-used after an indexed append is cleared to zero. When the buffer is finalized, the packer clears everything from the free position up to the next 64-byte boundary, one word per cycle. It then reports the tail length in bytes. A commit pulse empties the buffer pointers for the next batch. A simple read port lets the consumer, or a test, read back the stored words.

Top module: `idx_cmd_packer`

## Requirements
- R1: A direct request that fits stores two words at the free position: first the value, then the command word {8'h01, 4'hF, offset[19:0]}. The free position advances by 2.
- R2: An indexed request that does not merge first rounds the free position up to an even word index. It then stores three words: the count 1, the command word {8'h09, 4'h0, offset[19:0]}, and the value.
- R3: An indexed request whose offset equals the offset of the open instruction, where that instruction is itself indexed, stores only its value at the free position. It also rewrites the count word at the instruction start with the count plus one.
- R4: After any indexed request, if the free position is odd, the word at the free position is written to zero. The free position does not move.
- R5: A direct request becomes the open instruction. An indexed request to the same offset that follows it starts a new indexed instruction and does not merge.
- R6: A request whose words would not all fit in the DEPTH-word buffer is dropped. Nothing is written, the free position is unchanged, and overflow goes high and stays high until a commit.
- R7: A finalize pulse zero-fills every word from the free position up to the next multiple of 16 words. It then gives a one-cycle fin_done pulse, with tail_bytes equal to free position × 4 rounded up to a multiple of 64. Words at or beyond the tail are untouched.
- R8: A commit pulse in the idle state sets the free position and the instruction start to zero, clears overflow and closes the open instruction. The next request is stored from word 0.
- R9: req_ready is low from the cycle after an accepted request that fits, and from the cycle after a finalize, until the packer is idle again.
- R10: rd_data returns the buffer word at rd_addr one clock after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Packer can take a request this cycle |
| req_indexed | input | 1 | 1 = indexed write, 0 = direct write |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Register value |
| fin_start | input | 1 | Finalize pulse (taken when idle) |
| fin_done | output | 1 | One-cycle pulse when zero-fill completes |
| tail_bytes | output | 9 | Padded buffer length in bytes |
| commit | input | 1 | Reset buffer pointers (taken when idle) |
| overflow | output | 1 | Sticky flag: a request was dropped |
| rd_addr | input | 6 | Buffer read address (in words) |
| rd_data | output | 32 | Buffer word, one cycle after rd_addr |

## Verification
The bench goes after the merge path. A packer that compared only offsets would merge an indexed write into a preceding direct write to the same register and corrupt that command word. A packer that forgot the back-patch would leave the count at 1. The bench checks the alignment step taken from an odd free position and the zero pad word. Without them, a stale word would sit inside the instruction stream. It also loads the buffer with nonzero data, commits, and then finalizes a shorter batch. This shows that the fill clears stale words up to the 64-byte tail and stops there. The overflow test fills the buffer exactly and then offers one more request. Finalize then shows the free position unchanged, which exposes a packer that wrapped the pointer or wrote past the end.

// File: rtl/packer_pkg.sv
package packer_pkg;

  localparam int OFS_W   = 20;
  localparam int DATA_W  = 32;

  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;
  localparam logic [3:0] ALL_BYTES  = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DVAL,
    ST_DCMD,
    ST_ICNT,
    ST_ICMD,
    ST_IVAL,
    ST_MVAL,
    ST_MCNT,
    ST_PAD,
    ST_FILL
  } pk_state_e;

  function automatic logic [DATA_W-1:0] direct_word(input logic [OFS_W-1:0] ofs);
    return {OP_DIRECT, ALL_BYTES, ofs};
  endfunction

  function automatic logic [DATA_W-1:0] indexed_word(input logic [OFS_W-1:0] ofs);
    return {OP_INDEXED, 4'h0, ofs};
  endfunction

endpackage

// File: rtl/pk_buf_ram.sv
module pk_buf_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pk_tail_calc.sv
module pk_tail_calc #(
  parameter int DEPTH   = 64,
  parameter int LINE_DW = 16,
  localparam int PW     = $clog2(DEPTH) + 1
) (
  input  logic [PW-1:0] free_pos,
  output logic [PW-1:0] line_end
);

  localparam logic [PW-1:0] LMASK = PW'(LINE_DW - 1);

  // round the word position up to the next full line
  always_comb line_end = (free_pos + LMASK) & ~LMASK;

endmodule

// File: rtl/pk_emit_fsm.sv
module pk_emit_fsm
  import packer_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_indexed,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_value,
  input  logic              fin_start,
  input  logic              commit,
  input  logic [PW-1:0]     line_end,
  output logic              req_ready,
  output logic              busy,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PW-1:0]     free_pos,
  output logic [PW-1:0]     ins_start,
  output logic [PW-1:0]     fill_end,
  output logic              overflow,
  output logic              fin_done
);

  localparam logic [PW:0] CAP = (PW+1)'(DEPTH);

  pk_state_e         state;
  logic [OFS_W-1:0]  lat_ofs;
  logic [DATA_W-1:0] lat_val;
  logic              open_v, open_idx;
  logic [OFS_W-1:0]  open_ofs;
  logic [PW-1:0]     cnt;
  logic [PW-1:0]     fill_ptr;

  logic [PW:0] fp_x, al_x;
  logic        room_dir, room_idx, room_one, merge_hit;

  always_comb begin
    fp_x      = {1'b0, free_pos};
    al_x      = fp_x + (PW+1)'(free_pos[0]);
    room_dir  = (fp_x + (PW+1)'(2)) <= CAP;
    room_idx  = (al_x + (PW+1)'(3)) <= CAP;
    room_one  = fp_x < CAP;
    merge_hit = open_v && open_idx && (open_ofs == req_offset);
  end

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE) && !commit && !fin_start;

  // write port: one word per cycle
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = free_pos[AW-1:0];
    wr_data = '0;
    unique case (state)
      ST_DVAL: begin wr_en = 1'b1; wr_data = lat_val; end
      ST_DCMD: begin wr_en = 1'b1; wr_data = direct_word(lat_ofs); end
      ST_ICNT: begin wr_en = 1'b1; wr_data = DATA_W'(1); end
      ST_ICMD: begin wr_en = 1'b1; wr_data = indexed_word(lat_ofs); end
      ST_IVAL: begin wr_en = 1'b1; wr_data = lat_val; end
      ST_MVAL: begin wr_en = 1'b1; wr_data = lat_val; end
      ST_MCNT: begin
        wr_en   = 1'b1;
        wr_addr = ins_start[AW-1:0];
        wr_data = DATA_W'(cnt);
      end
      ST_PAD:  begin wr_en = free_pos[0]; wr_data = '0; end
      ST_FILL: begin
        wr_en   = (fill_ptr != fill_end);
        wr_addr = fill_ptr[AW-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      free_pos  <= '0;
      ins_start <= '0;
      fill_end  <= '0;
      fill_ptr  <= '0;
      overflow  <= 1'b0;
      fin_done  <= 1'b0;
      open_v    <= 1'b0;
      open_idx  <= 1'b0;
      open_ofs  <= '0;
      cnt       <= '0;
      lat_ofs   <= '0;
      lat_val   <= '0;
    end else begin
      fin_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (commit) begin
            free_pos  <= '0;
            ins_start <= '0;
            open_v    <= 1'b0;
            overflow  <= 1'b0;
          end else if (fin_start) begin
            fill_ptr <= free_pos;
            fill_end <= line_end;
            state    <= ST_FILL;
          end else if (req_valid) begin
            lat_ofs <= req_offset;
            lat_val <= req_value;
            if (!req_indexed) begin
              if (room_dir) state <= ST_DVAL;
              else          overflow <= 1'b1;
            end else if (merge_hit) begin
              if (room_one) state <= ST_MVAL;
              else          overflow <= 1'b1;
            end else if (room_idx) begin
              free_pos  <= al_x[PW-1:0];
              ins_start <= al_x[PW-1:0];
              state     <= ST_ICNT;
            end else begin
              overflow <= 1'b1;
            end
          end
        end
        ST_DVAL: begin
          ins_start <= free_pos;
          free_pos  <= free_pos + PW'(1);
          state     <= ST_DCMD;
        end
        ST_DCMD: begin
          free_pos <= free_pos + PW'(1);
          open_v   <= 1'b1;
          open_idx <= 1'b0;
          open_ofs <= lat_ofs;
          state    <= ST_IDLE;
        end
        ST_ICNT: begin
          free_pos <= free_pos + PW'(1);
          cnt      <= PW'(1);
          state    <= ST_ICMD;
        end
        ST_ICMD: begin
          free_pos <= free_pos + PW'(1);
          state    <= ST_IVAL;
        end
        ST_IVAL: begin
          free_pos <= free_pos + PW'(1);
          open_v   <= 1'b1;
          open_idx <= 1'b1;
          open_ofs <= lat_ofs;
          state    <= ST_PAD;
        end
        ST_MVAL: begin
          free_pos <= free_pos + PW'(1);
          cnt      <= cnt + PW'(1);
          state    <= ST_MCNT;
        end
        ST_MCNT: state <= ST_PAD;
        ST_PAD:  state <= ST_IDLE;
        ST_FILL: begin
          if (fill_ptr == fill_end) begin
            fin_done <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            fill_ptr <= fill_ptr + PW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/idx_cmd_packer.sv
module idx_cmd_packer
  import packer_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LINE_DW = 16,
  localparam int PW     = $clog2(DEPTH) + 1,
  localparam int AW     = $clog2(DEPTH),
  localparam int TW     = PW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_indexed,
  input  logic [19:0]       req_offset,
  input  logic [31:0]       req_value,
  input  logic              fin_start,
  output logic              fin_done,
  output logic [TW-1:0]     tail_bytes,
  input  logic              commit,
  output logic              overflow,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data
);

  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [PW-1:0]     free_pos, ins_start, fill_end, line_end;
  logic              emit_busy;

  pk_tail_calc #(.DEPTH(DEPTH), .LINE_DW(LINE_DW)) tail_i (
    .free_pos (free_pos),
    .line_end (line_end)
  );

  pk_emit_fsm #(.DEPTH(DEPTH)) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_indexed (req_indexed),
    .req_offset  (req_offset),
    .req_value   (req_value),
    .fin_start   (fin_start),
    .commit      (commit),
    .line_end    (line_end),
    .req_ready   (req_ready),
    .busy        (emit_busy),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .free_pos    (free_pos),
    .ins_start   (ins_start),
    .fill_end    (fill_end),
    .overflow    (overflow),
    .fin_done    (fin_done)
  );

  pk_buf_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) ram_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign tail_bytes = {fill_end, 2'b00};

endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int TW   = PW + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          commit,
  input logic          fin_done,
  input logic [TW-1:0] tail_bytes,
  input logic          overflow,
  input logic          busy,
  input logic [PW-1:0] free_pos,
  input logic [PW-1:0] ins_start
);

  p_fp_bound_r6: assert property (@(posedge clk) disable iff (rst)
    free_pos <= PW'(DEPTH));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    overflow && !commit |=> overflow);

  p_start_below_fp_r3: assert property (@(posedge clk) disable iff (rst)
    ins_start <= free_pos);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    fin_done |=> !fin_done);

  p_tail_line_r7: assert property (@(posedge clk) disable iff (rst)
    fin_done |-> (tail_bytes[5:0] == 6'd0));

  p_commit_clear_r8: assert property (@(posedge clk) disable iff (rst)
    commit && !busy |=> (free_pos == '0) && (ins_start == '0) && !overflow);

  p_busy_stall_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

endmodule

bind idx_cmd_packer pk_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .commit     (commit),
  .fin_done   (fin_done),
  .tail_bytes (tail_bytes),
  .overflow   (overflow),
  .busy       (emit_busy),
  .free_pos   (free_pos),
  .ins_start  (ins_start)
);

// File: tb/idx_cmd_packer_tb_top.sv
module idx_cmd_packer_tb_top;

  localparam int DEPTH = 64;
  localparam int PW    = $clog2(DEPTH) + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int TW    = PW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_indexed = 1'b0;
  logic [19:0]   req_offset = '0;
  logic [31:0]   req_value = '0;
  logic          fin_start = 1'b0;
  logic          fin_done;
  logic [TW-1:0] tail_bytes;
  logic          commit = 1'b0;
  logic          overflow;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  idx_cmd_packer #(.DEPTH(DEPTH)) dut_i (
    .clk, .rst, .req_valid, .req_ready, .req_indexed, .req_offset,
    .req_value, .fin_start, .fin_done, .tail_bytes, .commit, .overflow,
    .rd_addr, .rd_data
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
  endtask

  // issue one request; expect_busy says whether it should be taken in
  task automatic send(input bit idx, input logic [19:0] ofs,
                      input logic [31:0] val, input bit expect_busy);
    wait_ready();
    req_valid = 1'b1; req_indexed = idx; req_offset = ofs; req_value = val;
    @(negedge clk);
    req_valid = 1'b0;
    if (expect_busy)
      check(!req_ready, "R9", "ready low after accept", req_ready, 0);
    wait_ready();
  endtask

  task automatic rd_chk(input int addr, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(negedge clk);
    check(rd_data === exp, req, $sformatf("word[%0d]", addr), rd_data, exp);
  endtask

  task automatic finalize(input int exp_tail, input string req);
    bit seen = 1'b0;
    wait_ready();
    fin_start = 1'b1;
    @(negedge clk);
    fin_start = 1'b0;
    check(!req_ready, "R9", "ready low during fill", req_ready, 0);
    for (int i = 0; i < 200 && !seen; i++) begin
      if (fin_done) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, "R7", "fin_done pulse", seen, 1);
    check(tail_bytes == TW'(exp_tail), req, "tail_bytes", tail_bytes, exp_tail);
    @(negedge clk);
    check(!fin_done, "R7", "fin_done single cycle", fin_done, 0);
  endtask

  task automatic do_commit();
    wait_ready();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  function automatic logic [31:0] dcmd(input logic [19:0] o);
    return {8'h01, 4'hF, o};
  endfunction
  function automatic logic [31:0] icmd(input logic [19:0] o);
    return {8'h09, 4'h0, o};
  endfunction

  task automatic t_reset();
    check(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    check(overflow == 1'b0, "R6", "overflow after reset", overflow, 0);
    check(fin_done == 1'b0, "R7", "fin_done after reset", fin_done, 0);
    finalize(0, "R7");
  endtask

  // fill the buffer exactly, then one more direct request must be dropped
  task automatic t_overflow();
    for (int i = 0; i < DEPTH / 2; i++)
      send(1'b0, 20'(i), 32'hA000_0000 + i, 1'b1);
    check(!overflow, "R6", "no overflow at exact fill", overflow, 0);
    send(1'b0, 20'h00777, 32'hDEAD_BEEF, 1'b0);
    check(overflow, "R6", "overflow set on drop", overflow, 1);
    send(1'b1, 20'h00778, 32'hDEAD_BEEF, 1'b0);
    check(overflow, "R6", "overflow stays set", overflow, 1);
    rd_chk(DEPTH - 2, 32'hA000_0000 + DEPTH / 2 - 1, "R6");
    rd_chk(DEPTH - 1, dcmd(20'(DEPTH / 2 - 1)), "R6");
    finalize(DEPTH * 4, "R6");   // free position unchanged
    rd_chk(0, 32'hA000_0000, "R10");
    do_commit();
    check(!overflow, "R8", "overflow cleared by commit", overflow, 0);
  endtask

  task automatic t_pack();
    send(1'b0, 20'h12345, 32'h1111_0001, 1'b1);          // R1 words 0..1
    rd_chk(0, 32'h1111_0001, "R1");
    rd_chk(1, dcmd(20'h12345), "R1");
    send(1'b1, 20'h00100, 32'h2222_0002, 1'b1);          // R2 words 2..4, pad 5
    rd_chk(2, 32'd1, "R2");
    rd_chk(3, icmd(20'h00100), "R2");
    rd_chk(4, 32'h2222_0002, "R2");
    rd_chk(5, 32'd0, "R4");
    send(1'b1, 20'h00100, 32'h3333_0003, 1'b1);          // R3 merge at 5
    rd_chk(5, 32'h3333_0003, "R3");
    rd_chk(2, 32'd2, "R3");
    send(1'b1, 20'h00100, 32'h4444_0004, 1'b1);          // R3 merge at 6, pad 7
    rd_chk(6, 32'h4444_0004, "R3");
    rd_chk(2, 32'd3, "R3");
    rd_chk(7, 32'd0, "R4");
    send(1'b1, 20'h00200, 32'h5555_0005, 1'b1);          // R2 from odd 7 -> 8
    rd_chk(8, 32'd1, "R2");
    rd_chk(9, icmd(20'h00200), "R2");
    rd_chk(10, 32'h5555_0005, "R2");
    rd_chk(11, 32'd0, "R4");
    send(1'b0, 20'h00200, 32'h6666_0006, 1'b1);          // direct at odd 11
    rd_chk(11, 32'h6666_0006, "R1");
    rd_chk(12, dcmd(20'h00200), "R1");
    send(1'b1, 20'h00200, 32'h7777_0007, 1'b1);          // R5 new instr at 14
    rd_chk(14, 32'd1, "R5");
    rd_chk(15, icmd(20'h00200), "R5");
    rd_chk(16, 32'h7777_0007, "R5");
    rd_chk(17, 32'd0, "R4");
    rd_chk(12, dcmd(20'h00200), "R5");                   // direct word intact
    finalize(128, "R7");                                 // 17 words -> 2 lines
    for (int a = 18; a < 32; a++) rd_chk(a, 32'd0, "R7");
    rd_chk(32, 32'hA000_0010, "R7");                     // beyond tail untouched
  endtask

  task automatic t_after_commit();
    do_commit();
    send(1'b1, 20'h00200, 32'h8888_0008, 1'b1);          // must not merge
    rd_chk(0, 32'd1, "R8");
    rd_chk(1, icmd(20'h00200), "R8");
    rd_chk(2, 32'h8888_0008, "R8");
    rd_chk(3, 32'd0, "R4");
    finalize(64, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_overflow();
    t_pack();
    t_after_commit();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-reqs actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule